// File: doc/BRIEF.md
# PCI Bus Cycle Classifier

A passive monitor that watches the control lines of a PCI bus and tags every clock with a set of active-low cycle bits. The bits are idle, data transfer, initiator wait, target wait, wait-for-select, retry, target abort, master abort and end of transaction. The bus lines are registered on entry, and every bit is decoded from that registered copy. A tracking state machine follows each transaction, so the bits for a sampled clock appear on the outputs in the cycle after the edge that captured that clock. Two error flags report protocol faults: a completed handshake that no target claimed, and a target claiming a special cycle.

A store qualifier is provided for a trace buffer. In state mode, two control inputs can remove wait clocks and idle clocks from capture. In timing mode the qualifier is always high.

The tracking machine has three states:
- `ST_IDLE`: no transaction is open.
- `ST_DATA`: data phases are in progress.
- `ST_DRAIN`: an aborted transaction is still holding FRAME#.

It has four transitions:
- `ST_IDLE`→`ST_DATA` on an address phase, when FRAME# is low while idle.
- `ST_DATA`→`ST_IDLE` on end of transaction with FRAME# high.
- `ST_DATA`→`ST_DRAIN` on end of transaction with FRAME# still low.
- `ST_DRAIN`→`ST_IDLE` once FRAME# is high.

Top module: `pci_cycle_classifier`

## Requirements
- R1: While reset is held and on the first clock after it, every output bit except `idle_n` is inactive. This means the active-low bits are 1, and `err_nodev`, `err_special` are 0. `idle_n` is 0 and `store_o` is 1.
- R2: `idle_n` is 0 exactly when the registered FRAME# and IRDY# are both high. Every cycle bit refers to the bus values captured at the previous rising edge.
- R3: `dvalid_n` is 0 on a data-phase clock in which IRDY# and TRDY# are both low.
- R4: On a data-phase clock with STOP# high, three wait bits can fire. `iwait_n` is 0 when DEVSEL# is low and IRDY# is high. `twait_n` is 0 when DEVSEL#, IRDY# are low and TRDY# is high. `nodev_wait_n` is 0 when DEVSEL# has not yet been low in the transaction and no master abort fires.
- R5: `retry_n` is 0 when STOP# and DEVSEL# are low and TRDY# is high, before any data has moved in the transaction.
- R6: `tabort_n` is 0 for one clock when STOP# is low and DEVSEL# is high after DEVSEL# was low earlier in the transaction.
- R7: The master-abort counter counts data-phase clocks without DEVSEL#, starting on the clock after the address phase. `mabort_n` is 0 for one clock on the 5th such clock when FRAME# is high (single transfer), or on the 6th when FRAME# is low (multi-beat).
- R8: `eot_n` is 0 for one clock on the last clock of a transaction. That clock is a master or target abort, or a clock with FRAME# high, IRDY# low and TRDY# or STOP# low.
- R9: In state mode (`state_mode`=1), `store_o` is 0 on wait clocks when `drop_wait`=1 and on idle clocks when `drop_idle`=1. Otherwise it is 1.
- R10: In timing mode (`state_mode`=0), `store_o` is 1 on every clock regardless of `drop_wait` and `drop_idle`.
- R11: `err_nodev` is 1 on a data-phase clock of a non-special command with IRDY# and TRDY# low and DEVSEL# high.
- R12: `err_special` is 1 on a data-phase clock of a special cycle with DEVSEL# low.
- R13: The command is the C/BE# value taken on the address phase, and the special cycle is encoded 4'b0001. C/BE# values during data phases do not change the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| trdy_n | input | 1 | TRDY# from the bus |
| stop_n | input | 1 | STOP# from the bus |
| devsel_n | input | 1 | DEVSEL# from the bus |
| cbe_n | input | 4 | C/BE# lines from the bus |
| state_mode | input | 1 | 1 = state mode, 0 = timing mode |
| drop_wait | input | 1 | Exclude wait clocks from capture (state mode) |
| drop_idle | input | 1 | Exclude idle clocks from capture (state mode) |
| idle_n | output | 1 | Bus idle, active low |
| dvalid_n | output | 1 | Data transferred, active low |
| iwait_n | output | 1 | Initiator wait, active low |
| twait_n | output | 1 | Target wait, active low |
| nodev_wait_n | output | 1 | Wait for DEVSEL#, active low |
| retry_n | output | 1 | Retry, active low |
| tabort_n | output | 1 | Target abort, active low |
| mabort_n | output | 1 | Master abort, active low |
| eot_n | output | 1 | Last clock of a transaction, active low |
| store_o | output | 1 | Store qualifier for trace capture |
| err_nodev | output | 1 | Handshake completed with no target selected |
| err_special | output | 1 | DEVSEL# asserted during a special cycle |

## Verification
Master abort and end of transaction are meant to fall on the same clock. This is provoked with transactions that no target ever claims. A single read holds FRAME# high, and both bits must go low together on the fifth data clock and not before. A burst holds FRAME# low, and the shared clock must move to the sixth, with the fifth showing only the select wait. The same pairing is judged for target abort, where the abort and the transaction end must coincide and the select wait must stay silent because DEVSEL# had been seen.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_DRAIN = 2'd2
    } pcc_state_e;

    // Registered copy of the monitored bus lines (levels as on the wires)
    typedef struct packed {
        logic       frame_n;
        logic       irdy_n;
        logic       trdy_n;
        logic       stop_n;
        logic       devsel_n;
        logic [3:0] cbe_n;
    } pcc_bus_t;

    // Classification of one sampled clock, active high inside the block
    typedef struct packed {
        logic idle;
        logic dvalid;
        logic iwait;
        logic twait;
        logic nodev;
        logic retry;
        logic tabort;
        logic mabort;
        logic eot;
        logic err_nodev;
        logic err_special;
    } pcc_flags_t;

    localparam logic [3:0] CMD_SPECIAL = 4'b0001;

endpackage

// File: rtl/pcc_sampler.sv
module pcc_sampler
    import pcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pcc_bus_t bus_i,
    output pcc_bus_t bus_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '1;
        else        bus_q <= bus_i;
    end

endmodule

// File: rtl/pcc_tracker.sv
module pcc_tracker
    import pcc_pkg::*;
#(
    parameter int SINGLE_LIMIT = 5,
    parameter int MULTI_LIMIT  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pcc_bus_t   bus,
    output pcc_flags_t flags
);

    localparam int CW = $clog2(MULTI_LIMIT + 1);
    localparam logic [CW-1:0] LIM_S = CW'(SINGLE_LIMIT);
    localparam logic [CW-1:0] LIM_M = CW'(MULTI_LIMIT);

    pcc_state_e    state, state_nx;
    logic [CW-1:0] cnt;
    logic          dev_seen, xfer_seen;
    logic [3:0]    cmd;

    logic in_data, addr_ph, irdy, trdy, stop, devsel, last, special;
    logic [CW-1:0] cnt_nx, lim;

    assign irdy    = !bus.irdy_n;
    assign trdy    = !bus.trdy_n;
    assign stop    = !bus.stop_n;
    assign devsel  = !bus.devsel_n;
    assign last    = bus.frame_n;
    assign in_data = (state == ST_DATA);
    assign addr_ph = (state == ST_IDLE) && !bus.frame_n;
    assign special = (cmd == CMD_SPECIAL);
    assign cnt_nx  = cnt + 1'b1;
    assign lim     = last ? LIM_S : LIM_M;

    // Output decode of the current sampled clock
    always_comb begin
        flags             = '0;
        flags.idle        = bus.frame_n && bus.irdy_n;
        flags.dvalid      = in_data && irdy && trdy;
        flags.mabort      = in_data && !devsel && !dev_seen && (cnt_nx >= lim);
        flags.tabort      = in_data && stop && !devsel && dev_seen;
        flags.retry       = in_data && stop && devsel && !trdy && !xfer_seen;
        flags.iwait       = in_data && !stop && devsel && !irdy;
        flags.twait       = in_data && !stop && devsel && irdy && !trdy;
        flags.nodev       = in_data && !stop && !devsel && !dev_seen && !flags.mabort;
        flags.eot         = in_data && (flags.mabort || flags.tabort ||
                                        (last && irdy && (trdy || stop)));
        flags.err_nodev   = in_data && !special && irdy && trdy && !devsel;
        flags.err_special = in_data && special && devsel;
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!bus.frame_n) state_nx = ST_DATA;
            ST_DATA:  if (flags.eot)    state_nx = last ? ST_IDLE : ST_DRAIN;
            ST_DRAIN: if (bus.frame_n)  state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Per-transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            dev_seen  <= 1'b0;
            xfer_seen <= 1'b0;
            cmd       <= '1;
        end else if (addr_ph) begin
            cnt       <= '0;
            dev_seen  <= 1'b0;
            xfer_seen <= 1'b0;
            cmd       <= bus.cbe_n;
        end else if (in_data) begin
            if (devsel)       dev_seen  <= 1'b1;
            if (flags.dvalid) xfer_seen <= 1'b1;
            if (devsel || dev_seen || flags.eot) cnt <= '0;
            else                                 cnt <= cnt_nx;
        end else begin
            cnt <= '0;
        end
    end

    AST_MABORT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        flags.mabort |=> !flags.mabort);                                   // R7
    AST_MABORT_ENDS_XACT: assert property (@(posedge clk) disable iff (!rst_n)
        flags.mabort |-> flags.eot && !flags.nodev);                       // R7
    AST_TABORT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        flags.tabort |=> !flags.tabort);                                   // R6
    AST_EOT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        flags.eot |=> !flags.eot);                                         // R8
    AST_NO_WAIT_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        flags.dvalid |-> !flags.iwait && !flags.twait);                    // R4

endmodule

// File: rtl/pcc_store_gate.sv
module pcc_store_gate
    import pcc_pkg::*;
(
    input  pcc_flags_t flags,
    input  logic       state_mode,
    input  logic       drop_wait,
    input  logic       drop_idle,
    output logic       store
);

    logic any_wait;
    assign any_wait = flags.iwait || flags.twait || flags.nodev;

    always_comb begin
        store = 1'b1;
        if (state_mode) begin
            if (drop_wait && any_wait)    store = 1'b0;
            if (drop_idle && flags.idle)  store = 1'b0;
        end
    end

endmodule

// File: rtl/pci_cycle_classifier.sv
module pci_cycle_classifier
    import pcc_pkg::*;
#(
    parameter int SINGLE_LIMIT = 5,
    parameter int MULTI_LIMIT  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic       irdy_n,
    input  logic       trdy_n,
    input  logic       stop_n,
    input  logic       devsel_n,
    input  logic [3:0] cbe_n,
    input  logic       state_mode,
    input  logic       drop_wait,
    input  logic       drop_idle,
    output logic       idle_n,
    output logic       dvalid_n,
    output logic       iwait_n,
    output logic       twait_n,
    output logic       nodev_wait_n,
    output logic       retry_n,
    output logic       tabort_n,
    output logic       mabort_n,
    output logic       eot_n,
    output logic       store_o,
    output logic       err_nodev,
    output logic       err_special
);

    pcc_bus_t   bus_raw, bus_q;
    pcc_flags_t flags;

    assign bus_raw = '{frame_n: frame_n, irdy_n: irdy_n, trdy_n: trdy_n,
                       stop_n: stop_n, devsel_n: devsel_n, cbe_n: cbe_n};

    pcc_sampler u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .bus_i (bus_raw),
        .bus_q (bus_q)
    );

    pcc_tracker #(
        .SINGLE_LIMIT (SINGLE_LIMIT),
        .MULTI_LIMIT  (MULTI_LIMIT)
    ) u_tracker (
        .clk   (clk),
        .rst_n (rst_n),
        .bus   (bus_q),
        .flags (flags)
    );

    pcc_store_gate u_gate (
        .flags      (flags),
        .state_mode (state_mode),
        .drop_wait  (drop_wait),
        .drop_idle  (drop_idle),
        .store      (store_o)
    );

    assign idle_n       = !flags.idle;
    assign dvalid_n     = !flags.dvalid;
    assign iwait_n      = !flags.iwait;
    assign twait_n      = !flags.twait;
    assign nodev_wait_n = !flags.nodev;
    assign retry_n      = !flags.retry;
    assign tabort_n     = !flags.tabort;
    assign mabort_n     = !flags.mabort;
    assign eot_n        = !flags.eot;
    assign err_nodev    = flags.err_nodev;
    assign err_special  = flags.err_special;

    AST_DATA_ALWAYS_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid_n |-> store_o);                                            // R9
    AST_TIMING_STORES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !state_mode && !idle_n |-> store_o);                               // R10

endmodule

// File: tb/pci_cycle_classifier_test.sv
module pci_cycle_classifier_test;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1, irdy_n = 1, trdy_n = 1, stop_n = 1, devsel_n = 1;
    logic [3:0] cbe_n = 4'hF;
    logic state_mode = 1, drop_wait = 0, drop_idle = 0;
    logic idle_n, dvalid_n, iwait_n, twait_n, nodev_wait_n, retry_n;
    logic tabort_n, mabort_n, eot_n, store_o, err_nodev, err_special;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cycle_classifier uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n), .cbe_n(cbe_n),
        .state_mode(state_mode), .drop_wait(drop_wait), .drop_idle(drop_idle),
        .idle_n(idle_n), .dvalid_n(dvalid_n), .iwait_n(iwait_n), .twait_n(twait_n),
        .nodev_wait_n(nodev_wait_n), .retry_n(retry_n), .tabort_n(tabort_n),
        .mabort_n(mabort_n), .eot_n(eot_n), .store_o(store_o),
        .err_nodev(err_nodev), .err_special(err_special)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one bus clock; on return the outputs describe that clock
    task automatic cyc(input logic f, input logic i, input logic t,
                       input logic s, input logic d, input logic [3:0] c);
        frame_n = f; irdy_n = i; trdy_n = t; stop_n = s; devsel_n = d; cbe_n = c;
        @(negedge clk);
    endtask

    task automatic go_idle();
        cyc(1, 1, 1, 1, 1, 4'hF);
    endtask

    task automatic t_reset();
        chk("R1 idle in reset", idle_n, 1'b0);
        chk("R1 eot in reset", eot_n, 1'b1);
        repeat (2) @(negedge clk);
        rst_n = 1;
        go_idle();
        chk("R1 idle", idle_n, 1'b0);
        chk("R1 dvalid", dvalid_n, 1'b1);
        chk("R1 mabort", mabort_n, 1'b1);
        chk("R1 store", store_o, 1'b1);
        chk("R1 err", err_nodev | err_special, 1'b0);
    endtask

    task automatic t_single_read();
        cyc(0, 1, 1, 1, 1, 4'b0110);
        chk("R2 addr not idle", idle_n, 1'b1);
        cyc(1, 0, 1, 1, 1, 4'h0);
        chk("R4 nodev wait", nodev_wait_n, 1'b0);
        cyc(1, 0, 1, 1, 0, 4'h0);
        chk("R4 target wait", twait_n, 1'b0);
        chk("R4 nodev off", nodev_wait_n, 1'b1);
        cyc(1, 0, 0, 1, 0, 4'h0);
        chk("R3 dvalid", dvalid_n, 1'b0);
        chk("R8 eot", eot_n, 1'b0);
        go_idle();
        chk("R2 idle after", idle_n, 1'b0);
        chk("R8 eot one clk", eot_n, 1'b1);
    endtask

    task automatic t_burst_store();
        drop_wait = 1;
        cyc(0, 1, 1, 1, 1, 4'b0111);
        cyc(0, 1, 0, 1, 0, 4'h0);
        chk("R4 initiator wait", iwait_n, 1'b0);
        chk("R9 wait dropped", store_o, 1'b0);
        cyc(0, 0, 0, 1, 0, 4'h0);
        chk("R3 burst dvalid", dvalid_n, 1'b0);
        chk("R8 no eot mid burst", eot_n, 1'b1);
        chk("R9 data stored", store_o, 1'b1);
        cyc(1, 0, 0, 1, 0, 4'h0);
        chk("R8 burst eot", eot_n, 1'b0);
        drop_wait = 0; drop_idle = 1;
        go_idle();
        chk("R9 idle dropped", store_o, 1'b0);
        state_mode = 0; drop_wait = 1;
        go_idle();
        chk("R10 timing idle stored", store_o, 1'b1);
        cyc(0, 1, 1, 1, 1, 4'b0110);
        cyc(1, 0, 1, 1, 0, 4'h0);
        chk("R10 timing wait stored", store_o, 1'b1);
        cyc(1, 0, 0, 1, 0, 4'h0);
        go_idle();
        state_mode = 1; drop_wait = 0; drop_idle = 0;
        go_idle();
        chk("R9 filters off", store_o, 1'b1);
    endtask

    task automatic t_mabort_single();
        cyc(0, 1, 1, 1, 1, 4'b0110);
        for (int k = 1; k <= 4; k++) begin
            cyc(1, 0, 1, 1, 1, 4'h0);
            chk("R7 single no early abort", mabort_n, 1'b1);
        end
        cyc(1, 0, 1, 1, 1, 4'h0);
        chk("R7 single abort on 5th", mabort_n, 1'b0);
        chk("R8 eot with mabort", eot_n, 1'b0);
        chk("R4 no nodev on abort", nodev_wait_n, 1'b1);
        go_idle();
        chk("R7 mabort one clk", mabort_n, 1'b1);
    endtask

    task automatic t_mabort_multi();
        cyc(0, 1, 1, 1, 1, 4'b0111);
        for (int k = 1; k <= 5; k++) begin
            cyc(0, 0, 1, 1, 1, 4'h0);
            chk("R7 multi no abort before 6th", mabort_n, 1'b1);
        end
        chk("R4 nodev on 5th", nodev_wait_n, 1'b0);
        cyc(0, 0, 1, 1, 1, 4'h0);
        chk("R7 multi abort on 6th", mabort_n, 1'b0);
        chk("R8 eot multi abort", eot_n, 1'b0);
        cyc(1, 0, 1, 1, 1, 4'h0);
        chk("R8 drain no eot", eot_n, 1'b1);
        chk("R4 drain no wait", nodev_wait_n, 1'b1);
        go_idle();
        chk("R2 idle after drain", idle_n, 1'b0);
    endtask

    task automatic t_retry();
        cyc(0, 1, 1, 1, 1, 4'b0110);
        cyc(0, 0, 1, 0, 0, 4'h0);
        chk("R5 retry", retry_n, 1'b0);
        chk("R8 no eot frame low", eot_n, 1'b1);
        cyc(1, 0, 1, 0, 0, 4'h0);
        chk("R8 retry eot", eot_n, 1'b0);
        go_idle();
        cyc(0, 1, 1, 1, 1, 4'b0111);
        cyc(0, 0, 0, 1, 0, 4'h0);
        cyc(1, 0, 1, 0, 0, 4'h0);
        chk("R5 no retry after data", retry_n, 1'b1);
        go_idle();
    endtask

    task automatic t_tabort();
        cyc(0, 1, 1, 1, 1, 4'b0110);
        cyc(1, 0, 1, 1, 0, 4'h0);
        cyc(1, 0, 1, 0, 1, 4'h0);
        chk("R6 tabort", tabort_n, 1'b0);
        chk("R8 eot tabort", eot_n, 1'b0);
        chk("R4 no nodev after seen", nodev_wait_n, 1'b1);
        go_idle();
        chk("R6 tabort one clk", tabort_n, 1'b1);
    endtask

    task automatic t_errors();
        cyc(0, 1, 1, 1, 1, 4'b0110);
        cyc(1, 0, 0, 1, 1, 4'b0001);
        chk("R11 nodev error", err_nodev, 1'b1);
        go_idle();
        chk("R11 error clears", err_nodev, 1'b0);
        cyc(0, 1, 1, 1, 1, 4'b0001);
        cyc(0, 0, 1, 1, 0, 4'b0110);
        chk("R12 special devsel", err_special, 1'b1);
        cyc(1, 1, 1, 1, 1, 4'hF);
        go_idle();
        cyc(0, 1, 1, 1, 1, 4'b0001);
        cyc(1, 0, 0, 1, 1, 4'b0110);
        chk("R13 special no nodev err", err_nodev, 1'b0);
        chk("R13 special no devsel err", err_special, 1'b0);
        go_idle();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single_read();
        t_burst_store();
        t_mabort_single();
        t_mabort_multi();
        t_retry();
        t_tabort();
        t_errors();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule